// File: doc/BRIEF.md
# Burst Access Start and Selection Controller

This block sits in front of a synchronous burst memory and decides on every rising clock edge whether a new access begins. It also decides whether the device takes part in that access and whether the access reads or writes. Two active-low address-status strobes can start an access. One is meant for a processor and the other for a memory controller. Three chip enables of mixed polarity are looked at only when a strobe actually loads a new address. The result is kept until the next load.

The registered outputs drive the rest of the memory:
- a selection flag;
- a one-cycle load pulse for the burst address sequencer;
- an advance pulse for continuation cycles;
- a cycle-type code.

Read data leaves the array one clock after its cycle is registered. The block therefore delays the read indication by a parameterised number of stages. It then gates the result with an asynchronous active-low output enable to form the data-driver enable.

Top module: `burst_select_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `selected`, `load_addr` and `advance` become 0, `cyc_type` becomes 0 (idle) and `drive_en` is 0.
- R2: When `adsp_n` is 0 and `ce_n` is 0, a new access starts. `selected` and `load_addr` become 1 only if `ce2` is 1 and `ce3_n` is 0, and otherwise both become 0. A selected access of this kind is always a read (`cyc_type` 1), whatever the write controls say.
- R3: While `ce_n` is 1, the processor strobe `adsp_n` has no effect. If `adsc_n` is also 1, the cycle behaves as a continuation.
- R4: When `adsc_n` is 0 and the processor strobe is not taking effect, a new access starts. The device is selected with a load pulse only if `ce_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination deselects it, with no load and `cyc_type` 0.
- R5: A selected controller-strobe access is a write (`cyc_type` 2) when `gw_n` is 0. It is also a write when `bwe_n` is 0 and at least one bit of `bw_n` is 0. In every other case it is a read (`cyc_type` 1).
- R6: When both strobes are 0 and `ce_n` is 0, the processor strobe wins and the access is a read.
- R7: In a cycle with no strobe taking effect, `selected` keeps its value, `load_addr` is 0, and all chip enables are ignored.
- R8: In a continuation cycle, `cyc_type` follows the write controls (rule of R5) while selected. It is 0 while deselected.
- R9: `advance` is 1 after a continuation edge where the device was selected and `adv_n` was 0. It is 0 otherwise, and never 1 together with `load_addr`.
- R10: `drive_en` is 1 exactly when `oe_n` is 0 and `cyc_type` was 1 (read) READ_LAT clock edges earlier (default 1). `oe_n` acts without waiting for a clock.
- R11: After the device is deselected, `drive_en` falls to 0 once the pending read stage has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adsp_n | input | 1 | Processor address-status strobe, active low |
| adsc_n | input | 1 | Controller address-status strobe, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Expansion chip enable, active high |
| ce3_n | input | 1 | Expansion chip enable, active low |
| adv_n | input | 1 | Burst advance request, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | LANES | Per-lane write requests, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| selected | output | 1 | Registered device selection |
| load_addr | output | 1 | Pulse: sequencer loads the external address |
| advance | output | 1 | Pulse: sequencer steps the burst address |
| cyc_type | output | 2 | 0 idle, 1 read, 2 write |
| drive_en | output | 1 | Data output driver enable |

## Verification
The bench drives a processor strobe while the primary enable is high. A design that fails to ignore it would drop or change the selection. It also applies both strobes at once, where a controller-strobe priority would turn a read into a write. It separates the byte-write gate from the lane bits, since a design that treated a low lane bit alone as a write would mark plain reads as writes. The bench also steps through continuation cycles with enables toggling, which a design that sampled enables on every edge would get wrong. Finally it follows the driver enable one cycle behind reads, through writes and a deselect, so a pipeline that is off by one stage shows up at once.

// File: rtl/burst_sel_pkg.sv
package burst_sel_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    // Decision taken from the strobes and enables for one clock edge
    typedef struct packed {
        logic take_p;   // processor strobe takes effect
        logic take_c;   // controller strobe takes effect
        logic enabled;  // all three chip enables active
        logic wr_req;   // write controls request a write
    } start_t;

    function automatic cyc_e pick_rw(input logic wr);
        return wr ? CYC_WRITE : CYC_READ;
    endfunction

endpackage

// File: rtl/acc_start_decode.sv
module acc_start_decode
    import burst_sel_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output start_t           dec
);
    localparam logic [LANES-1:0] NO_LANE = {LANES{1'b1}};

    always_comb begin
        dec.take_p  = !adsp_n && !ce_n;
        dec.take_c  = !adsc_n && !dec.take_p;
        dec.enabled = !ce_n && ce2 && !ce3_n;
        dec.wr_req  = !gw_n || (!bwe_n && (bw_n != NO_LANE));
    end
endmodule

// File: rtl/acc_select_reg.sv
module acc_select_reg
    import burst_sel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  start_t dec,
    input  logic   adv_n,
    output logic   sel,
    output logic   load,
    output logic   step,
    output cyc_e   cyc
);
    logic new_acc;
    assign new_acc = dec.take_p || dec.take_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= 1'b0;
            load <= 1'b0;
            step <= 1'b0;
            cyc  <= CYC_IDLE;
        end else if (new_acc) begin
            sel  <= dec.enabled;
            load <= dec.enabled;
            step <= 1'b0;
            if (!dec.enabled)
                cyc <= CYC_IDLE;
            else if (dec.take_p)
                cyc <= CYC_READ;
            else
                cyc <= pick_rw(dec.wr_req);
        end else begin
            load <= 1'b0;
            step <= sel && !adv_n;
            cyc  <= sel ? pick_rw(dec.wr_req) : CYC_IDLE;
        end
    end

    // R2: processor strobe with full enables gives a selected read
    a_r2_proc_read: assert property (@(posedge clk) disable iff (rst)
        (dec.take_p && dec.enabled) |=> (sel && load && cyc == CYC_READ));

    // R4: controller strobe with an inactive enable deselects
    a_r4_deselect: assert property (@(posedge clk) disable iff (rst)
        (dec.take_c && !dec.enabled) |=> (!sel && !load && cyc == CYC_IDLE));

    // R7: no new access keeps the selection
    a_r7_hold_sel: assert property (@(posedge clk) disable iff (rst)
        !new_acc |=> ($stable(sel) && !load));

    // R9: advance and load never together, advance only while selected
    a_r9_step_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load, step}));
    a_r9_step_sel: assert property (@(posedge clk) disable iff (rst)
        step |-> sel);
endmodule

// File: rtl/acc_drive_pipe.sv
module acc_drive_pipe
    import burst_sel_pkg::*;
#(
    parameter int READ_LAT = 1
) (
    input  logic clk,
    input  logic rst,
    input  cyc_e cyc,
    input  logic oe_n,
    output logic drive_en
);
    logic [READ_LAT-1:0] rd_sr;
    logic                is_rd;
    assign is_rd = (cyc == CYC_READ);

    generate
        if (READ_LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) rd_sr <= '0;
                else     rd_sr <= is_rd;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) rd_sr <= '0;
                else     rd_sr <= {rd_sr[READ_LAT-2:0], is_rd};
            end
        end
    endgenerate

    assign drive_en = !oe_n && rd_sr[READ_LAT-1];

    // R10: output enable high always blocks the drivers
    a_r10_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drive_en);

    generate
        if (READ_LAT == 1) begin : g_chk
            logic armed;
            always_ff @(posedge clk) begin
                if (rst) armed <= 1'b0;
                else     armed <= 1'b1;
            end
            // R10: drivers follow the read registered one edge earlier
            a_r10_latency: assert property (@(posedge clk) disable iff (rst)
                armed |-> (drive_en == (!oe_n && $past(cyc == CYC_READ))));
        end
    endgenerate
endmodule

// File: rtl/burst_select_ctrl.sv
module burst_select_ctrl
    import burst_sel_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int READ_LAT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             ce_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    output logic             selected,
    output logic             load_addr,
    output logic             advance,
    output logic [1:0]       cyc_type,
    output logic             drive_en
);
    start_t dec;
    cyc_e   cyc;

    acc_start_decode #(.LANES(LANES)) u_dec (
        .adsp_n (adsp_n),
        .adsc_n (adsc_n),
        .ce_n   (ce_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .dec    (dec)
    );

    acc_select_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .adv_n (adv_n),
        .sel   (selected),
        .load  (load_addr),
        .step  (advance),
        .cyc   (cyc)
    );

    acc_drive_pipe #(.READ_LAT(READ_LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .cyc      (cyc),
        .oe_n     (oe_n),
        .drive_en (drive_en)
    );

    assign cyc_type = cyc;

    // R3: processor strobe ignored while primary enable is high
    a_r3_proc_ignored: assert property (@(posedge clk) disable iff (rst)
        (ce_n && adsc_n) |=> ($stable(selected) && !load_addr));

    // R11: a deselected device holding idle cycles never drives
    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        (!selected && $past(!selected) && $past(!load_addr)) |-> !drive_en);
endmodule

// File: tb/tb_burst_select_ctrl.sv
`timescale 1ns/1ps
module tb_burst_select_ctrl;
    localparam int LANES = 4;
    localparam int NV    = 18;

    logic clk = 1'b0;
    logic rst;
    logic adsp_n, adsc_n, ce_n, ce2, ce3_n, adv_n, gw_n, bwe_n, oe_n;
    logic [LANES-1:0] bw_n;
    logic selected, load_addr, advance, drive_en;
    logic [1:0] cyc_type;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_select_ctrl #(.LANES(LANES), .READ_LAT(1)) dut (
        .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .ce_n(ce_n),
        .ce2(ce2), .ce3_n(ce3_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .selected(selected), .load_addr(load_addr),
        .advance(advance), .cyc_type(cyc_type), .drive_en(drive_en)
    );

    // fields: adsp adsc ce ce2 ce3 adv gw bwe bw[3:0] | sel load step cyc[1:0]
    localparam logic [16:0] VEC [0:NV-1] = '{
        17'b1_1_1_0_1_1_1_1_1111_0_0_0_00, // R7 idle
        17'b0_1_1_1_0_1_1_1_1111_0_0_0_00, // R3 ignored
        17'b0_1_0_1_0_1_0_1_1111_1_1_0_01, // R2 read despite gw
        17'b1_1_0_1_0_0_1_1_1111_1_0_1_01, // R9 advance
        17'b1_1_1_0_1_1_1_0_1011_1_0_0_10, // R7 enables ignored, R8 write
        17'b0_1_1_1_0_0_1_1_1111_1_0_1_01, // R3 ignored while selected
        17'b1_0_0_0_0_1_1_1_1111_0_0_0_00, // R4 ce2 low
        17'b1_1_0_1_0_0_0_1_1111_0_0_0_00, // R8 deselected idle
        17'b1_0_0_1_0_1_0_1_1111_1_1_0_10, // R5 gw write
        17'b1_0_0_1_0_1_1_0_1111_1_1_0_01, // R5 no lane read
        17'b1_0_0_1_0_1_1_0_1110_1_1_0_10, // R5 lane write
        17'b1_0_0_1_0_1_1_1_0000_1_1_0_01, // R5 lanes without gate
        17'b1_0_0_1_1_1_1_1_1111_0_0_0_00, // R4 ce3 high
        17'b0_0_0_1_0_1_0_1_1111_1_1_0_01, // R6 processor wins
        17'b1_0_1_1_0_1_1_1_1111_0_0_0_00, // R4 ce high
        17'b0_1_0_0_0_1_1_1_1111_0_0_0_00, // R2 enables deselect
        17'b1_0_0_1_0_1_0_1_1111_1_1_0_10, // R5 write again
        17'b0_0_1_1_0_1_1_1_1111_0_0_0_00  // R3 controller acts
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R7";   1: return "R3";   2: return "R2";
            3: return "R9";   4: return "R8";   5: return "R3";
            6: return "R4";   7: return "R8";   8: return "R5";
            9: return "R5";   10: return "R5";  11: return "R5";
            12: return "R4";  13: return "R6";  14: return "R4";
            15: return "R2";  16: return "R5";  default: return "R3";
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] v);
        @(negedge clk);
        {adsp_n, adsc_n, ce_n, ce2, ce3_n, adv_n, gw_n, bwe_n, bw_n} = v;
        @(negedge clk);
    endtask

    function automatic logic [11:0] nostrobe(input logic gw);
        return {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, gw, 1'b1, 4'hF};
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        done = 1'b1;
    end

    initial begin
        rst = 1'b1; oe_n = 1'b0;
        {adsp_n, adsc_n, ce_n, ce2, ce3_n, adv_n, gw_n, bwe_n, bw_n} = nostrobe(1'b1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check({4'd0, selected, load_addr, advance, drive_en}, 8'd0, "R1 flags");
        check({6'd0, cyc_type}, 8'd0, "R1 cyc");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][16:5]);
            check({3'd0, selected, load_addr, advance, cyc_type},
                  {3'd0, VEC[i][4:0]}, vtag(i));
        end

        // R10 driver pipeline, state now deselected and idle
        apply(nostrobe(1'b1));
        apply({1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF}); // read starts
        check({7'd0, drive_en}, 8'd0, "R10 not yet");
        apply({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF}); // read continues
        check({7'd0, drive_en}, 8'd1, "R10 one edge later");
        oe_n = 1'b1; #1;
        check({7'd0, drive_en}, 8'd0, "R10 oe async off");
        oe_n = 1'b0; #1;
        check({7'd0, drive_en}, 8'd1, "R10 oe async on");
        apply({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF}); // write cycle
        check({7'd0, drive_en}, 8'd1, "R10 prior read drains");
        apply({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF}); // read again
        check({7'd0, drive_en}, 8'd0, "R10 after write");
        apply({1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF}); // deselect
        check({7'd0, drive_en}, 8'd1, "R11 pending read");
        apply(nostrobe(1'b1));
        check({7'd0, drive_en}, 8'd0, "R11 drained");
        check({7'd0, selected}, 8'd0, "R11 deselected");

        // R1 reset while selected
        apply({1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF});
        check({7'd0, selected}, 8'd1, "R1 pre-reset select");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({4'd0, selected, load_addr, advance, drive_en}, 8'd0, "R1 mid-run flags");
        check({6'd0, cyc_type}, 8'd0, "R1 mid-run cyc");
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule